// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a small 32-bit load/store core and decides, once per enabled cycle, which address is fetched next. It offers the current address and the address four bytes beyond it, and it chooses between the sequential address, a PC-relative conditional branch target, a region-relative absolute jump target, and the fixed exception vector. The two conditional branches (taken on equal and taken on not-equal) are decided from the zero flag that the ALU produces when it subtracts the two compared registers.

When an illegal-opcode or arithmetic-overflow request arrives in an enabled cycle, the unit records the address of the offending instruction in an exception program counter register, records a one-bit cause, and redirects fetch to the vector address. An enable input freezes the program counter and the exception state so that pipeline stalls can hold fetch in place. The instruction memory is outside the block; only the low 26 bits of the fetched word are needed, because they hold both the branch offset and the jump index.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset sets `pc` to 0x00000000, `epc` to 0 and `cause` to 0 on the next rising clock edge.
- R2: In an enabled cycle with no exception, jump or taken branch, `pc` becomes `pc + 4` (wrapping modulo 2^32).
- R3: A taken branch sets `pc` to `pc + 4` plus the offset in `instr_field[15:0]`, sign-extended and multiplied by 4; an offset of 0 gives `pc + 4` and an offset of 0xFFFF gives the branch's own address.
- R4: With `is_beq` high the branch is taken only when `zero` is 1; with `is_bne` high it is taken only when `zero` is 0; otherwise the sequential address is used.
- R5: A jump sets `pc` to bits [31:28] of `pc + 4`, then `instr_field[25:0]`, then two zero bits.
- R6: An exception request in an enabled cycle sets `pc` to the vector (default 0x80000180) and stores the current `pc` in `epc`.
- R7: On exception entry `cause` becomes 0 for an illegal opcode and 1 for overflow; when both requests are high together, the illegal opcode wins and `cause` becomes 0.
- R8: Priority is exception over jump, and jump over conditional branch.
- R9: When `en` is low, `pc`, `epc` and `cause` keep their values and exception requests are ignored.
- R10: `pc` is always word aligned and `pc_plus4` always equals `pc + 4`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Update enable; low stalls the unit |
| instr_field | input | 26 | Low 26 bits of the fetched instruction (jump index; bits 15:0 are the branch offset) |
| zero | input | 1 | ALU zero flag from comparing the branch operands |
| is_beq | input | 1 | Decoded branch-if-equal strobe |
| is_bne | input | 1 | Decoded branch-if-not-equal strobe |
| is_jump | input | 1 | Decoded absolute jump strobe |
| exc_illegal | input | 1 | Illegal opcode exception request |
| exc_ovf | input | 1 | Arithmetic overflow exception request |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 |
| epc | output | 32 | Address of the last instruction that raised an exception |
| cause | output | 1 | Last exception cause: 0 illegal opcode, 1 overflow |

## Verification
The assertions follow every cycle: alignment and the `pc_plus4` relation, the hold of all state during a stall, the vector and saved address after an exception, the cause bit, and the sequential, jump and taken-branch destinations. Only the bench scenarios can show the full sweep of all 128 combinations of the control strobes, the zero flag and the enable, which proves the priority order as a whole. The same holds for offsets at the signed extremes, for branches that wrap around the address space, and for jumps made from the upper half of memory, where the kept region bits are not zero.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_BR   = 2'd1,
    NPC_JMP  = 2'd2,
    NPC_EXC  = 2'd3
  } npc_sel_e;

  typedef enum logic {
    CAUSE_ILLEGAL  = 1'b0,
    CAUSE_OVERFLOW = 1'b1
  } npc_cause_e;

endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [JIDX_W-1:0] instr_field,
  output logic [XLEN-1:0]   seq_addr,
  output logic [XLEN-1:0]   br_addr,
  output logic [XLEN-1:0]   jmp_addr
);
  localparam int EXT_W    = XLEN - OFF_W - 2;
  localparam int REGION_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] br_disp;

  always_comb begin
    seq_addr = pc + XLEN'(4);
    br_disp  = {{EXT_W{instr_field[OFF_W-1]}}, instr_field[OFF_W-1:0], 2'b00};
    br_addr  = seq_addr + br_disp;
    jmp_addr = {seq_addr[XLEN-1 -: REGION_W], instr_field, 2'b00};
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  logic     zero,
  input  logic     is_beq,
  input  logic     is_bne,
  input  logic     is_jump,
  input  logic     exc_any,
  output npc_sel_e sel
);
  logic br_taken;

  always_comb begin
    br_taken = (is_beq && zero) || (is_bne && !zero);
    if (exc_any)       sel = NPC_EXC;
    else if (is_jump)  sel = NPC_JMP;
    else if (br_taken) sel = NPC_BR;
    else               sel = NPC_SEQ;
  end

endmodule

// File: rtl/npc_exc_regs.sv
module npc_exc_regs
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            exc_illegal,
  input  logic            exc_ovf,
  input  logic [XLEN-1:0] cur_pc,
  output logic [XLEN-1:0] epc,
  output logic            cause
);
  npc_cause_e cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc     <= '0;
      cause_q <= CAUSE_ILLEGAL;
    end else if (en && (exc_illegal || exc_ovf)) begin
      epc     <= cur_pc;
      cause_q <= exc_illegal ? CAUSE_ILLEGAL : CAUSE_OVERFLOW;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          JIDX_W   = 26,
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter logic [31:0] VECTOR   = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [JIDX_W-1:0] instr_field,
  input  logic              zero,
  input  logic              is_beq,
  input  logic              is_bne,
  input  logic              is_jump,
  input  logic              exc_illegal,
  input  logic              exc_ovf,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   pc_plus4,
  output logic [XLEN-1:0]   epc,
  output logic              cause
);
  logic [XLEN-1:0] seq_addr, br_addr, jmp_addr, nxt;
  npc_sel_e        sel;
  logic            exc_any;

  assign exc_any = exc_illegal || exc_ovf;

  npc_targets #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_targets (
    .pc          (pc),
    .instr_field (instr_field),
    .seq_addr    (seq_addr),
    .br_addr     (br_addr),
    .jmp_addr    (jmp_addr)
  );

  npc_select u_select (
    .zero    (zero),
    .is_beq  (is_beq),
    .is_bne  (is_bne),
    .is_jump (is_jump),
    .exc_any (exc_any),
    .sel     (sel)
  );

  npc_exc_regs #(.XLEN(XLEN)) u_exc (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .exc_illegal (exc_illegal),
    .exc_ovf     (exc_ovf),
    .cur_pc      (pc),
    .epc         (epc),
    .cause       (cause)
  );

  always_comb begin
    unique case (sel)
      NPC_EXC: nxt = XLEN'(VECTOR);
      NPC_JMP: nxt = jmp_addr;
      NPC_BR:  nxt = br_addr;
      default: nxt = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     pc <= XLEN'(RESET_PC);
    else if (en) pc <= nxt;
  end

  assign pc_plus4 = seq_addr;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int          XLEN   = 32,
  parameter int          OFF_W  = 16,
  parameter int          JIDX_W = 26,
  parameter logic [31:0] VECTOR = 32'h8000_0180
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [JIDX_W-1:0] instr_field,
  input logic              zero,
  input logic              is_beq,
  input logic              is_bne,
  input logic              is_jump,
  input logic              exc_illegal,
  input logic              exc_ovf,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   pc_plus4,
  input logic [XLEN-1:0]   epc,
  input logic              cause
);
  localparam int EXT_W    = XLEN - OFF_W - 2;
  localparam int REGION_W = XLEN - JIDX_W - 2;

  logic exc_req, ctl_none, br_hit;
  assign exc_req  = exc_illegal || exc_ovf;
  assign br_hit   = (is_beq && zero) || (is_bne && !zero);
  assign ctl_none = !exc_req && !is_jump && !br_hit;

  // R10
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00 && pc_plus4 - pc == XLEN'(4));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc) && $stable(epc) && $stable(cause));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    en && ctl_none |=> pc == $past(pc) + XLEN'(4));

  // R6
  exc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    en && exc_req |=> pc == XLEN'(VECTOR) && epc == $past(pc));

  // R7
  cause_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    en && exc_illegal |=> cause == 1'b0);

  // R7
  cause_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    en && exc_ovf && !exc_illegal |=> cause == 1'b1);

  // R5 R8
  jump_dest_chk: assert property (@(posedge clk) disable iff (rst)
    en && is_jump && !exc_req |=>
      pc[XLEN-1 -: REGION_W] == $past(pc_plus4[XLEN-1 -: REGION_W]) &&
      pc[JIDX_W+1:2] == $past(instr_field) && pc[1:0] == 2'b00);

  // R3 R4
  branch_dest_chk: assert property (@(posedge clk) disable iff (rst)
    en && br_hit && !is_jump && !exc_req |=>
      pc == $past(pc) + XLEN'(4) +
            {{EXT_W{$past(instr_field[OFF_W-1])}}, $past(instr_field[OFF_W-1:0]), 2'b00});

endmodule

bind npc_unit npc_unit_chk #(
  .XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W), .VECTOR(VECTOR)
) u_npc_chk (
  .clk(clk), .rst(rst), .en(en), .instr_field(instr_field), .zero(zero),
  .is_beq(is_beq), .is_bne(is_bne), .is_jump(is_jump),
  .exc_illegal(exc_illegal), .exc_ovf(exc_ovf),
  .pc(pc), .pc_plus4(pc_plus4), .epc(epc), .cause(cause)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [25:0] instr_field = '0;
  logic        zero = 1'b0, is_beq = 1'b0, is_bne = 1'b0, is_jump = 1'b0;
  logic        exc_illegal = 1'b0, exc_ovf = 1'b0;
  logic [31:0] pc, pc_plus4, epc;
  logic        cause;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pc = '0, m_epc = '0;
  logic        m_cause = 1'b0;

  always #5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst(rst), .en(en), .instr_field(instr_field), .zero(zero),
    .is_beq(is_beq), .is_bne(is_bne), .is_jump(is_jump),
    .exc_illegal(exc_illegal), .exc_ovf(exc_ovf),
    .pc(pc), .pc_plus4(pc_plus4), .epc(epc), .cause(cause)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(pc == m_pc, req, "pc", pc, m_pc);
    chk(epc == m_epc, req, "epc", epc, m_epc);
    chk(cause == m_cause, req, "cause", {31'd0, cause}, {31'd0, m_cause});
    // R10: pc_plus4 tracks pc
    chk(pc_plus4 == m_pc + 32'd4, "R10", "pc_plus4", pc_plus4, m_pc + 32'd4);
  endtask

  // One enabled or stalled cycle; expected state worked out from the requirements.
  task automatic step(input logic [25:0] f, input logic z, input logic b, input logic n,
                      input logic j, input logic il, input logic ov, input logic e,
                      input string req);
    logic [31:0] p4, disp;
    @(negedge clk);
    instr_field = f; zero = z; is_beq = b; is_bne = n; is_jump = j;
    exc_illegal = il; exc_ovf = ov; en = e;
    p4   = m_pc + 32'd4;
    disp = {{14{f[15]}}, f[15:0], 2'b00};
    if (e) begin
      if (il || ov) begin
        m_epc   = m_pc;
        m_cause = il ? 1'b0 : 1'b1;
        m_pc    = VEC;
      end else if (j) begin
        m_pc = {p4[31:28], f, 2'b00};
      end else if ((b && z) || (n && !z)) begin
        m_pc = p4 + disp;
      end else begin
        m_pc = p4;
      end
    end
    @(posedge clk);
    #2;
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    m_pc = '0; m_epc = '0; m_cause = 1'b0;
    check_all("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R2: plain sequential fetch
    for (int i = 0; i < 6; i++) step(26'h3ff_ffff, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

    // R3 R4 R5: sweep offsets (including 0, -1 and the signed extremes) from varied bases
    for (int i = 0; i < 64; i++) begin
      logic [15:0] off;
      logic [25:0] base;
      case (i)
        0:       off = 16'h0000;
        1:       off = 16'hffff;
        2:       off = 16'h7fff;
        3:       off = 16'h8000;
        default: off = 16'(i * 1031 + 17);
      endcase
      base = 26'(i * 40503 + 7);
      step(base, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      for (int k = 0; k < 4; k++) begin
        logic [25:0] f;
        f = {10'h2a5, off};
        step(f, k[0], !k[1], k[1], 1'b0, 1'b0, 1'b0, 1'b1, "R3 R4");
      end
    end

    // R3: offset -1 branches to itself, repeatedly
    for (int i = 0; i < 3; i++) step(26'h000_ffff, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");

    // R6 R7: overflow from a known spot, then jump from the upper region
    step(26'h000_0040, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    step(26'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 R7");
    step(26'h123_4567, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    chk(pc[31:28] == 4'h8, "R5", "region bits", {28'd0, pc[31:28]}, 32'h8);
    step(26'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6 R7");

    // R8 R9 R6 R7: exhaustive sweep of strobes, zero flag and enable
    for (int c = 0; c < 128; c++) begin
      logic [6:0] v;
      string req;
      v = 7'(c);
      step(26'(c * 9973 + 3), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      if (!v[6])           req = "R9";
      else if (v[4] | v[5]) req = "R6 R7 R8";
      else                 req = "R8 R4";
      step(26'h155_0123 ^ 26'(c), v[0], v[1], v[2], v[3], v[4], v[5], v[6], req);
    end

    // R9: a long stall with exception requests present
    for (int i = 0; i < 5; i++) step(26'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");

    // R1: reset in the middle of a run
    step(26'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
    do_reset();
    step(26'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule